// File: doc/BRIEF.md
# Bus Node Fault-Confinement and Access Controller

This block is the top-level control engine of a node on a shared, message-based serial field bus. It holds the node's fault-confinement mode. The three modes are normal working, degraded (error passive) and fully disconnected (bus off). While the node is connected, it also runs an access engine with four substates: ready, send, receive and error.

Two flags gate the access engine. A data-pending flag records that one frame from the application waits to go out. A bus-free flag records that the medium may be claimed. The application side hands in one frame at a time with a request and receives an acceptance pulse. It gets back delivered frames through an indication pulse, plus confirmation pulses for a completed send and for a completed restart. The detailed transmit and receive sequencers sit next to this block. They are started through `txStart` and report results through single-cycle event inputs.

A transmit error counter and a receive error counter move on those events. Their values decide the mode changes. Every output is registered, so a response appears in the cycle after the input or event that caused it.

Top module: `nodeAccessCtrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the controller shows the following state. `nodeMode` is 0 (normal working) and `accessState` is 0 (ready). `dataPending` is 0 and `busFree` is 1. Both error counters are 0 and every pulse output is 0.
- R2: A request (`appReqValid`=1) is taken only when `dataPending` is 0 and the node is connected. Taking it stores `appReqFrame` on `txFrame`, sets `dataPending` and pulses `appReqAccept` for one cycle. A request made while a frame is pending leaves `txFrame` unchanged and gives no pulse.
- R3: In ready (`accessState`=0), with `dataPending`=1 and `busFree`=1, the engine moves to send (`accessState`=1) unless a bus frame is seen in the same cycle. This move clears `busFree` and pulses `txStart`.
- R4: In ready, `evBusFrame` moves the engine to receive (`accessState`=2) and clears `busFree`. It wins over a send that would start in the same cycle.
- R5: In send, `evArbLost` moves the engine to receive and clears `dataPending`.
- R6: In send, `evSendOk` does four things. It returns the engine to ready, clears `dataPending`, sets `busFree`, and pulses `sendConfirm`. It also lowers the transmit counter by 1, but not below 0.
- R7: In receive, `evRxOk` returns the engine to ready, pulses `indValid` with `indFrame` equal to `rxFrame` of that cycle, sets `busFree`, and lowers the receive counter by 1, but not below 0.
- R8: In send, `evSendErr` moves the engine to error (`accessState`=3) and adds 8 to the transmit counter; it takes priority over `evSendOk` and `evArbLost`. In receive, `evRxErr` moves the engine to error and adds 1 to the receive counter, which saturates at 255; it takes priority over `evRxOk`. In error, `evErrOver` returns the engine to ready and sets `busFree`.
- R9: `nodeMode` becomes 1 (error passive) one cycle after either counter is at 128 or more. It returns to 0 one cycle after both counters are below 128.
- R10: From the cycle the transmit counter exceeds 255, requests and events are ignored. One cycle later `nodeMode` is 2 (bus off). In that mode `busEnable` is 0, `accessState` is 0, and both flags are 0. Requests and every event except restart have no effect.
- R11: `evRestart` in bus off does the following. It sets `nodeMode` to 0, clears both counters and sets `busFree`. It also pulses `restartConfirm`. Outside bus off, `evRestart` has no effect.
- R12: An event that does not belong to the current substate changes neither the substate, the flags nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| appReqValid | input | 1 | Application offers a frame |
| appReqFrame | input | FRAME_W | Frame offered by the application |
| appReqAccept | output | 1 | Pulse: offered frame was taken |
| txStart | output | 1 | Pulse: start the transmit sequencer |
| txFrame | output | FRAME_W | Stored frame for the transmit sequencer |
| evArbLost | input | 1 | Transmit sequencer lost arbitration |
| evSendOk | input | 1 | Transmit sequencer finished a frame |
| evSendErr | input | 1 | Transmit sequencer reports an error |
| evBusFrame | input | 1 | A frame from another node has started on the bus |
| evRxOk | input | 1 | Receive sequencer delivered a good frame |
| evRxErr | input | 1 | Receive sequencer reports an error |
| evErrOver | input | 1 | Error signalling on the bus has ended |
| evRestart | input | 1 | Request to leave bus off |
| rxFrame | input | FRAME_W | Frame from the receive sequencer |
| indValid | output | 1 | Pulse: received frame delivered |
| indFrame | output | FRAME_W | Delivered frame |
| sendConfirm | output | 1 | Pulse: pending frame sent |
| restartConfirm | output | 1 | Pulse: restart out of bus off done |
| nodeMode | output | 2 | 0 normal, 1 error passive, 2 bus off |
| accessState | output | 2 | 0 ready, 1 send, 2 receive, 3 error |
| busEnable | output | 1 | Node may drive and sample the bus |
| dataPending | output | 1 | A frame waits to be sent |
| busFree | output | 1 | The medium may be claimed |
| txErrCount | output | TEC_W | Transmit error counter |
| rxErrCount | output | REC_W | Receive error counter |

## Verification
Some behaviour holds cycle by cycle and is checked by properties on every cycle. Bus off keeps the node quiet, with the engine in ready and the flags clear. Send is entered only from ready with both flags set. The mode follows a counter threshold crossing within one cycle. A send error adds exactly 8 to the transmit counter. A restart leaves the counters at zero. Other behaviour needs a scenario to show. That covers the priority of a bus frame over a pending send and the loss of the pending frame after lost arbitration. It also covers the full climb to bus off through error passive and the way back to normal working as the receive counter drops. A random mix of requests and events is compared against a reference model in the bench.

// File: rtl/nac_pkg.sv
package nac_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'd0,
    MODE_PASSIVE = 2'd1,
    MODE_OFF     = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SUB_READY = 2'd0,
    SUB_SEND  = 2'd1,
    SUB_RECV  = 2'd2,
    SUB_ERR   = 2'd3
  } sub_e;

  // strobes from the control engine to the datapath, one cycle wide
  typedef struct packed {
    logic storeReq;
    logic clrPending;
    logic setBusFree;
    logic clrBusFree;
    logic tecUp;
    logic tecDown;
    logic recUp;
    logic recDown;
    logic clrCounters;
    logic startTx;
    logic sendDone;
    logic deliver;
    logic restartDone;
  } strobe_t;

endpackage

// File: rtl/nacDatapath.sv
module nacDatapath
  import nac_pkg::*;
#(
  parameter int FRAME_W     = 32,
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int OFF_LIM     = 255,
  parameter int TEC_STEP    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            cmd,
  input  logic [FRAME_W-1:0] reqFrame,
  input  logic [FRAME_W-1:0] rxFrame,
  output logic               dataPending,
  output logic               busFree,
  output logic [TEC_W-1:0]   tec,
  output logic [REC_W-1:0]   rec,
  output logic               tecPassive,
  output logic               recPassive,
  output logic               tecOff,
  output logic [FRAME_W-1:0] txFrame,
  output logic [FRAME_W-1:0] indFrame,
  output logic               acceptPulse,
  output logic               txStartPulse,
  output logic               sendCnfPulse,
  output logic               indPulse,
  output logic               restartPulse
);

  localparam logic [TEC_W-1:0] TEC_MAX  = {TEC_W{1'b1}};
  localparam logic [REC_W-1:0] REC_MAX  = {REC_W{1'b1}};
  localparam logic [TEC_W:0]   TEC_INC  = (TEC_W+1)'(TEC_STEP);
  localparam logic [TEC_W-1:0] TEC_PAS  = TEC_W'(PASSIVE_LIM);
  localparam logic [REC_W-1:0] REC_PAS  = REC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFFL = TEC_W'(OFF_LIM);

  logic [TEC_W:0] tecSum;
  logic [TEC_W-1:0] tecNext;
  logic [REC_W-1:0] recNext;

  assign tecSum = {1'b0, tec} + TEC_INC;

  always_comb begin
    tecNext = tec;
    if (cmd.clrCounters) tecNext = '0;
    else if (cmd.tecUp) tecNext = tecSum[TEC_W] ? TEC_MAX : tecSum[TEC_W-1:0];
    else if (cmd.tecDown && tec != '0) tecNext = tec - 1'b1;
  end

  always_comb begin
    recNext = rec;
    if (cmd.clrCounters) recNext = '0;
    else if (cmd.recUp && rec != REC_MAX) recNext = rec + 1'b1;
    else if (cmd.recDown && rec != '0) recNext = rec - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataPending <= 1'b0;
      busFree     <= 1'b1;
      tec         <= '0;
      rec         <= '0;
      txFrame     <= '0;
      indFrame    <= '0;
    end else begin
      tec <= tecNext;
      rec <= recNext;
      if (cmd.clrPending) dataPending <= 1'b0;
      else if (cmd.storeReq) dataPending <= 1'b1;
      if (cmd.setBusFree) busFree <= 1'b1;
      else if (cmd.clrBusFree) busFree <= 1'b0;
      if (cmd.storeReq) txFrame <= reqFrame;
      if (cmd.deliver) indFrame <= rxFrame;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptPulse  <= 1'b0;
      txStartPulse <= 1'b0;
      sendCnfPulse <= 1'b0;
      indPulse     <= 1'b0;
      restartPulse <= 1'b0;
    end else begin
      acceptPulse  <= cmd.storeReq;
      txStartPulse <= cmd.startTx;
      sendCnfPulse <= cmd.sendDone;
      indPulse     <= cmd.deliver;
      restartPulse <= cmd.restartDone;
    end
  end

  assign tecPassive = tec >= TEC_PAS;
  assign recPassive = rec >= REC_PAS;
  assign tecOff     = tec > TEC_OFFL;

endmodule

// File: rtl/nacControl.sv
module nacControl
  import nac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    evArbLost,
  input  logic    evSendOk,
  input  logic    evSendErr,
  input  logic    evBusFrame,
  input  logic    evRxOk,
  input  logic    evRxErr,
  input  logic    evErrOver,
  input  logic    evRestart,
  input  logic    dataPending,
  input  logic    busFree,
  input  logic    tecPassive,
  input  logic    recPassive,
  input  logic    tecOff,
  output mode_e   mode,
  output sub_e    sub,
  output strobe_t cmd
);

  mode_e modeNext;
  sub_e  subNext;
  logic  linkUp;

  assign linkUp = (mode != MODE_OFF) && !tecOff;

  // fault-confinement mode, decided on the registered counter values
  always_comb begin
    modeNext = mode;
    cmd      = '0;
    subNext  = sub;
    if (mode == MODE_OFF) begin
      if (evRestart) begin
        modeNext        = MODE_ACTIVE;
        cmd.clrCounters = 1'b1;
        cmd.setBusFree  = 1'b1;
        cmd.restartDone = 1'b1;
      end
    end else if (tecOff) begin
      modeNext       = MODE_OFF;
      subNext        = SUB_READY;
      cmd.clrPending = 1'b1;
      cmd.clrBusFree = 1'b1;
    end else if (mode == MODE_ACTIVE && (tecPassive || recPassive)) begin
      modeNext = MODE_PASSIVE;
    end else if (mode == MODE_PASSIVE && !tecPassive && !recPassive) begin
      modeNext = MODE_ACTIVE;
    end

    // access engine, runs only while connected
    if (linkUp) begin
      if (reqValid && !dataPending) cmd.storeReq = 1'b1;
      unique case (sub)
        SUB_READY: begin
          if (evBusFrame) begin
            subNext        = SUB_RECV;
            cmd.clrBusFree = 1'b1;
          end else if (dataPending && busFree) begin
            subNext        = SUB_SEND;
            cmd.clrBusFree = 1'b1;
            cmd.startTx    = 1'b1;
          end
        end
        SUB_SEND: begin
          if (evSendErr) begin
            subNext   = SUB_ERR;
            cmd.tecUp = 1'b1;
          end else if (evSendOk) begin
            subNext        = SUB_READY;
            cmd.clrPending = 1'b1;
            cmd.setBusFree = 1'b1;
            cmd.tecDown    = 1'b1;
            cmd.sendDone   = 1'b1;
          end else if (evArbLost) begin
            subNext        = SUB_RECV;
            cmd.clrPending = 1'b1;
          end
        end
        SUB_RECV: begin
          if (evRxErr) begin
            subNext   = SUB_ERR;
            cmd.recUp = 1'b1;
          end else if (evRxOk) begin
            subNext        = SUB_READY;
            cmd.setBusFree = 1'b1;
            cmd.recDown    = 1'b1;
            cmd.deliver    = 1'b1;
          end
        end
        SUB_ERR: begin
          if (evErrOver) begin
            subNext        = SUB_READY;
            cmd.setBusFree = 1'b1;
          end
        end
        default: subNext = SUB_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= MODE_ACTIVE;
      sub  <= SUB_READY;
    end else begin
      mode <= modeNext;
      sub  <= subNext;
    end
  end

endmodule

// File: rtl/nodeAccessCtrl.sv
module nodeAccessCtrl
  import nac_pkg::*;
#(
  parameter int FRAME_W     = 32,
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int OFF_LIM     = 255,
  parameter int TEC_STEP    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               appReqValid,
  input  logic [FRAME_W-1:0] appReqFrame,
  output logic               appReqAccept,
  output logic               txStart,
  output logic [FRAME_W-1:0] txFrame,
  input  logic               evArbLost,
  input  logic               evSendOk,
  input  logic               evSendErr,
  input  logic               evBusFrame,
  input  logic               evRxOk,
  input  logic               evRxErr,
  input  logic               evErrOver,
  input  logic               evRestart,
  input  logic [FRAME_W-1:0] rxFrame,
  output logic               indValid,
  output logic [FRAME_W-1:0] indFrame,
  output logic               sendConfirm,
  output logic               restartConfirm,
  output logic [1:0]         nodeMode,
  output logic [1:0]         accessState,
  output logic               busEnable,
  output logic               dataPending,
  output logic               busFree,
  output logic [TEC_W-1:0]   txErrCount,
  output logic [REC_W-1:0]   rxErrCount
);

  strobe_t cmd;
  mode_e   mode;
  sub_e    sub;
  logic    tecPassive, recPassive, tecOff;

  nacControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (appReqValid),
    .evArbLost  (evArbLost),
    .evSendOk   (evSendOk),
    .evSendErr  (evSendErr),
    .evBusFrame (evBusFrame),
    .evRxOk     (evRxOk),
    .evRxErr    (evRxErr),
    .evErrOver  (evErrOver),
    .evRestart  (evRestart),
    .dataPending(dataPending),
    .busFree    (busFree),
    .tecPassive (tecPassive),
    .recPassive (recPassive),
    .tecOff     (tecOff),
    .mode       (mode),
    .sub        (sub),
    .cmd        (cmd)
  );

  nacDatapath #(
    .FRAME_W    (FRAME_W),
    .TEC_W      (TEC_W),
    .REC_W      (REC_W),
    .PASSIVE_LIM(PASSIVE_LIM),
    .OFF_LIM    (OFF_LIM),
    .TEC_STEP   (TEC_STEP)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .reqFrame    (appReqFrame),
    .rxFrame     (rxFrame),
    .dataPending (dataPending),
    .busFree     (busFree),
    .tec         (txErrCount),
    .rec         (rxErrCount),
    .tecPassive  (tecPassive),
    .recPassive  (recPassive),
    .tecOff      (tecOff),
    .txFrame     (txFrame),
    .indFrame    (indFrame),
    .acceptPulse (appReqAccept),
    .txStartPulse(txStart),
    .sendCnfPulse(sendConfirm),
    .indPulse    (indValid),
    .restartPulse(restartConfirm)
  );

  assign nodeMode    = mode;
  assign accessState = sub;
  assign busEnable   = (mode != MODE_OFF);

endmodule

// File: rtl/nodeAccessCtrlChecker.sv
module nodeAccessCtrlChecker #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int OFF_LIM     = 255,
  parameter int TEC_STEP    = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             appReqAccept,
  input logic             txStart,
  input logic             indValid,
  input logic             restartConfirm,
  input logic [1:0]       nodeMode,
  input logic [1:0]       accessState,
  input logic             busEnable,
  input logic             dataPending,
  input logic             busFree,
  input logic [TEC_W-1:0] txErrCount,
  input logic [REC_W-1:0] rxErrCount
);

  localparam logic [1:0] M_ACT = 2'd0, M_PAS = 2'd1, M_OFF = 2'd2;
  localparam logic [1:0] S_RDY = 2'd0, S_SND = 2'd1, S_RCV = 2'd2, S_ERR = 2'd3;

  AST_ACCEPT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    appReqAccept |-> (dataPending && !$past(dataPending))); // R2

  AST_SEND_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (accessState == S_SND && $past(accessState) != S_SND) |->
      ($past(accessState) == S_RDY && $past(dataPending) && $past(busFree) && txStart && !busFree)); // R3

  AST_SEND_HOLDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    accessState == S_SND |-> dataPending); // R5

  AST_IND_FROM_RECV: assert property (@(posedge clk) disable iff (!rstN)
    indValid |-> ($past(accessState) == S_RCV && accessState == S_RDY && busFree)); // R7

  AST_SEND_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (accessState == S_ERR && $past(accessState) == S_SND) |->
      (txErrCount == $past(txErrCount) + TEC_W'(TEC_STEP))); // R8

  AST_PASSIVE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (nodeMode == M_ACT && txErrCount <= TEC_W'(OFF_LIM) &&
     (txErrCount >= TEC_W'(PASSIVE_LIM) || rxErrCount >= REC_W'(PASSIVE_LIM))) |=> nodeMode == M_PAS); // R9

  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (nodeMode != M_OFF && txErrCount > TEC_W'(OFF_LIM)) |=> nodeMode == M_OFF); // R10

  AST_BUSOFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    nodeMode == M_OFF |-> (!busEnable && accessState == S_RDY && !dataPending && !busFree &&
                           !txStart && !indValid && !appReqAccept)); // R10

  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    restartConfirm |-> (nodeMode == M_ACT && txErrCount == '0 && rxErrCount == '0 && busFree &&
                        $past(nodeMode) == M_OFF)); // R11

endmodule

bind nodeAccessCtrl nodeAccessCtrlChecker #(
  .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_LIM(PASSIVE_LIM), .OFF_LIM(OFF_LIM), .TEC_STEP(TEC_STEP)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .appReqAccept  (appReqAccept),
  .txStart       (txStart),
  .indValid      (indValid),
  .restartConfirm(restartConfirm),
  .nodeMode      (nodeMode),
  .accessState   (accessState),
  .busEnable     (busEnable),
  .dataPending   (dataPending),
  .busFree       (busFree),
  .txErrCount    (txErrCount),
  .rxErrCount    (rxErrCount)
);

// File: tb/nodeAccessCtrl_test.sv
module nodeAccessCtrl_test;
  localparam int FW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic appReqValid, evArbLost, evSendOk, evSendErr, evBusFrame, evRxOk, evRxErr, evErrOver, evRestart;
  logic [FW-1:0] appReqFrame, rxFrame;
  logic appReqAccept, txStart, indValid, sendConfirm, restartConfirm, busEnable, dataPending, busFree;
  logic [FW-1:0] txFrame, indFrame;
  logic [1:0] nodeMode, accessState;
  logic [8:0] txErrCount;
  logic [7:0] rxErrCount;

  nodeAccessCtrl uut (
    .clk(clk), .rstN(rstN), .appReqValid(appReqValid), .appReqFrame(appReqFrame),
    .appReqAccept(appReqAccept), .txStart(txStart), .txFrame(txFrame),
    .evArbLost(evArbLost), .evSendOk(evSendOk), .evSendErr(evSendErr), .evBusFrame(evBusFrame),
    .evRxOk(evRxOk), .evRxErr(evRxErr), .evErrOver(evErrOver), .evRestart(evRestart),
    .rxFrame(rxFrame), .indValid(indValid), .indFrame(indFrame), .sendConfirm(sendConfirm),
    .restartConfirm(restartConfirm), .nodeMode(nodeMode), .accessState(accessState),
    .busEnable(busEnable), .dataPending(dataPending), .busFree(busFree),
    .txErrCount(txErrCount), .rxErrCount(rxErrCount)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int mMode, mSub, mTec, mRec;
  bit mPend, mFree, mAcc, mTxs, mScnf, mInd, mRcnf;
  logic [FW-1:0] mTxF, mIndF;

  task automatic chkEq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mMode = 0; mSub = 0; mTec = 0; mRec = 0;
    mPend = 0; mFree = 1; mAcc = 0; mTxs = 0; mScnf = 0; mInd = 0; mRcnf = 0;
    mTxF = '0; mIndF = '0;
  endtask

  // one clock of the behaviour the requirements describe
  task automatic modelStep();
    int nMode, nSub, nTec, nRec;
    bit nPend, nFree, up;
    nMode = mMode; nSub = mSub; nTec = mTec; nRec = mRec; nPend = mPend; nFree = mFree;
    mAcc = 0; mTxs = 0; mScnf = 0; mInd = 0; mRcnf = 0;
    up = (mMode != 2) && (mTec <= 255);
    if (mMode == 2) begin
      if (evRestart) begin
        nMode = 0; nTec = 0; nRec = 0; nFree = 1; mRcnf = 1;
      end
    end else if (mTec > 255) begin
      nMode = 2; nSub = 0; nPend = 0; nFree = 0;
    end else if (mMode == 0 && (mTec >= 128 || mRec >= 128)) nMode = 1;
    else if (mMode == 1 && mTec < 128 && mRec < 128) nMode = 0;
    if (up) begin
      if (appReqValid && !mPend) begin nPend = 1; mTxF = appReqFrame; mAcc = 1; end
      case (mSub)
        0: if (evBusFrame) begin nSub = 2; nFree = 0; end
           else if (mPend && mFree) begin nSub = 1; nFree = 0; mTxs = 1; end
        1: if (evSendErr) begin nSub = 3; nTec = mTec + 8; end
           else if (evSendOk) begin
             nSub = 0; nPend = 0; nFree = 1; mScnf = 1; if (mTec > 0) nTec = mTec - 1;
           end else if (evArbLost) begin nSub = 2; nPend = 0; end
        2: if (evRxErr) begin nSub = 3; if (mRec < 255) nRec = mRec + 1; end
           else if (evRxOk) begin
             nSub = 0; nFree = 1; mInd = 1; mIndF = rxFrame; if (mRec > 0) nRec = mRec - 1;
           end
        default: if (evErrOver) begin nSub = 0; nFree = 1; end
      endcase
    end
    mMode = nMode; mSub = nSub; mTec = nTec; mRec = nRec; mPend = nPend; mFree = nFree;
  endtask

  task automatic compareAll();
    chkEq("R9 nodeMode", nodeMode, mMode);
    chkEq("R12 accessState", accessState, mSub);
    chkEq("R2 dataPending", dataPending, mPend);
    chkEq("R3 busFree", busFree, mFree);
    chkEq("R8 txErrCount", txErrCount, mTec);
    chkEq("R8 rxErrCount", rxErrCount, mRec);
    chkEq("R2 appReqAccept", appReqAccept, mAcc);
    chkEq("R2 txFrame", txFrame, mTxF);
    chkEq("R3 txStart", txStart, mTxs);
    chkEq("R6 sendConfirm", sendConfirm, mScnf);
    chkEq("R7 indValid", indValid, mInd);
    if (mInd) chkEq("R7 indFrame", indFrame, mIndF);
    chkEq("R11 restartConfirm", restartConfirm, mRcnf);
    chkEq("R10 busEnable", busEnable, mMode != 2);
  endtask

  task automatic clearIn();
    appReqValid = 0; evArbLost = 0; evSendOk = 0; evSendErr = 0; evBusFrame = 0;
    evRxOk = 0; evRxErr = 0; evErrOver = 0; evRestart = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    modelStep();
    compareAll();
    clearIn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    int guard;
    bit sawPassive;
    logic [FW-1:0] keep;
    seedDummy = $urandom(32'h1A2B3C);
    clearIn();
    appReqFrame = '0; rxFrame = '0; rstN = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chkEq("R1 mode in reset", nodeMode, 0);
    chkEq("R1 busFree in reset", busFree, 1);
    rstN = 1;
    modelReset();
    cyc();
    chkEq("R1 state after reset", accessState, 0);
    chkEq("R1 counters after reset", txErrCount + rxErrCount, 0);

    // R12: stray events in ready with nothing pending
    evSendOk = 1; cyc(); evRxOk = 1; cyc(); evErrOver = 1; cyc(); evArbLost = 1; cyc();
    chkEq("R12 ready unchanged", accessState, 0);
    chkEq("R12 busFree unchanged", busFree, 1);

    // R2, R3, R6: accept, send, success
    appReqValid = 1; appReqFrame = 32'hCAFE_0001; cyc();
    chkEq("R2 accept pulse", appReqAccept, 1);
    appReqValid = 1; appReqFrame = 32'hDEAD_0002; cyc();
    chkEq("R3 in send", accessState, 1);
    chkEq("R3 txStart", txStart, 1);
    chkEq("R2 second request refused", appReqAccept, 0);
    chkEq("R2 frame kept", txFrame, 32'hCAFE_0001);
    evSendOk = 1; cyc();
    chkEq("R6 back to ready", accessState, 0);
    chkEq("R6 confirm", sendConfirm, 1);
    chkEq("R6 pending cleared", dataPending, 0);

    // R4, R7: bus frame wins over pending send, then delivery
    appReqValid = 1; appReqFrame = 32'h1111_2222; cyc();
    evBusFrame = 1; cyc();
    chkEq("R4 to receive", accessState, 2);
    chkEq("R4 no txStart", txStart, 0);
    rxFrame = 32'hABCD_1234; evRxOk = 1; cyc();
    chkEq("R7 indication", indValid, 1);
    chkEq("R7 indFrame", indFrame, 32'hABCD_1234);
    cyc();
    chkEq("R3 send after receive", accessState, 1);

    // R5: lost arbitration
    evArbLost = 1; cyc();
    chkEq("R5 to receive", accessState, 2);
    chkEq("R5 pending dropped", dataPending, 0);
    evRxErr = 1; cyc();
    chkEq("R8 rx error", rxErrCount, 1);
    evErrOver = 1; cyc();
    chkEq("R8 error over", accessState, 0);

    // R8: send error wins over send ok
    appReqValid = 1; cyc(); cyc();
    evSendErr = 1; evSendOk = 1; cyc();
    chkEq("R8 error priority", accessState, 3);
    chkEq("R8 tec plus 8", txErrCount, 8);
    evErrOver = 1; cyc();

    // R11: restart outside bus off is ignored
    evRestart = 1; cyc();
    chkEq("R11 ignored when connected", restartConfirm, 0);
    chkEq("R11 tec kept", txErrCount, 8);

    // R9, R10: climb to bus off through repeated send errors
    sawPassive = 0; guard = 0;
    while (mMode != 2 && guard < 400) begin
      case (mSub)
        0: appReqValid = 1;
        1: evSendErr = 1;
        2: evRxOk = 1;
        default: evErrOver = 1;
      endcase
      cyc();
      if (nodeMode == 1) sawPassive = 1;
      guard++;
    end
    chkEq("R9 passive seen", sawPassive, 1);
    chkEq("R10 bus off", nodeMode, 2);
    appReqValid = 1; evBusFrame = 1; cyc();
    chkEq("R10 request ignored", dataPending, 0);
    chkEq("R10 state ready", accessState, 0);
    chkEq("R10 disconnected", busEnable, 0);
    evRestart = 1; cyc();
    chkEq("R11 restart mode", nodeMode, 0);
    chkEq("R11 restart counters", txErrCount, 0);
    chkEq("R11 restart pulse", restartConfirm, 1);

    // R9: receive errors to passive, then back to normal working
    for (int i = 0; i < 128; i++) begin
      evBusFrame = 1; cyc(); evRxErr = 1; cyc(); evErrOver = 1; cyc();
    end
    cyc();
    chkEq("R9 passive by rx counter", nodeMode, 1);
    keep = 32'h7777_0000;
    rxFrame = keep; evBusFrame = 1; cyc(); evRxOk = 1; cyc();
    chkEq("R9 rec 127", rxErrCount, 127);
    cyc();
    chkEq("R9 back to active", nodeMode, 0);

    // random mix against the reference model
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 15);
      appReqValid = $urandom_range(0, 1);
      appReqFrame = $urandom();
      rxFrame = $urandom();
      case (r)
        0: evArbLost = 1;
        1: evSendOk = 1;
        2: evSendErr = 1;
        3: evBusFrame = 1;
        4: evRxOk = 1;
        5: evRxErr = 1;
        6: evErrOver = 1;
        7: evRestart = 1;
        8: begin evSendErr = 1; evSendOk = 1; end
        default: ;
      endcase
      cyc();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule